// File: doc/BRIEF.md
# Misaligned Load Data Aligner

This block sits between a load/store unit and a 32-bit memory read port. It takes one load request at a time, carrying a byte address, an access size and a signed flag. For each request it issues exactly one read to memory and returns the value as the processor will write it to a register. A misaligned address does not cause a fault, and the access is never split into two reads. A misaligned word or unsigned halfword returns the aligned data rotated. A signed halfword at an odd address is handled as a sign-extended byte load from that exact address.

Requests use a valid/ready handshake. The memory side is a one-cycle read strobe with address and size, and a data-return strobe that may arrive any number of cycles later. The formatted result is registered and presented with a one-cycle response strobe. Memory data arrives as a 32-bit word in little-endian byte-lane order: byte lane n holds the byte whose address has low bits n. Size codes are 0 for byte, 1 for halfword and 2 for word, and code 3 is handled as a word.

Top module: `load_aligner`

## Requirements
- R1: After reset, reqReady is 1, memRdValid is 0 and rspValid is 0.
- R2: A request is accepted on a clock edge where reqValid and reqReady are both 1. memRdValid is then 1 for exactly the next cycle. Each request produces exactly one read strobe.
- R3: reqReady is 0 from the cycle after acceptance until the cycle in which rspValid is 1. In that cycle reqReady is 1 again, so a new request can be accepted in the same cycle as the response.
- R4: memRdDone is accepted starting in the cycle after the read strobe. The cycle after memRdDone is accepted, rspValid is 1 for exactly one cycle, and rspData holds the formatted result.
- R5: A word load (size 2) at an address with low bits 00 reads size 2 at that address and returns memRdData unchanged.
- R6: A word load at an address with non-zero low bits A reads size 2 at the address with bits 1:0 cleared, and returns memRdData rotated right by 8*A bits.
- R7: An unsigned halfword load (size 1) at an even address reads size 1 at that address and returns the 16-bit lane memRdData[16*addr[1] +: 16], zero-extended.
- R8: An unsigned halfword load at an odd address reads size 1 at the address with bit 0 cleared. It takes that halfword lane, zero-extends it to 32 bits, and rotates the result right by 8 bits.
- R9: A signed halfword load at an even address returns the halfword lane sign-extended from its bit 15.
- R10: A signed halfword load at an odd address reads size 0 at the exact address and returns byte lane memRdData[8*addr[1:0] +: 8], sign-extended from bit 7.
- R11: A byte load (size 0) reads size 0 at the exact address. It returns byte lane memRdData[8*addr[1:0] +: 8], zero-extended when unsigned and sign-extended from bit 7 when signed.
- R12: memRdDone has no effect while no read is outstanding, including in the read-strobe cycle itself. rspValid stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Load request present |
| reqReady | output | 1 | Block can accept a request |
| reqAddr | input | ADDR_W | Byte address of the load |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 word |
| reqSigned | input | 1 | Sign-extend the result |
| memRdValid | output | 1 | One-cycle read strobe |
| memRdAddr | output | ADDR_W | Read address (aligned to memRdSize) |
| memRdSize | output | 2 | Effective read size, same codes |
| memRdDone | input | 1 | Read data is present on memRdData |
| memRdData | input | 32 | Read data word, little-endian byte lanes |
| rspValid | output | 1 | One-cycle response strobe |
| rspData | output | 32 | Formatted register value |

## Verification
Two functions can happen in the same cycle: delivering one response and accepting the next request. The bench provokes this by driving reqValid for a new load in the very cycle rspValid is high, with no idle gap between loads. It then checks that the response data is correct and that the new read strobe follows exactly one cycle later. A reference model in the bench computes every expected value from the address, size, signed flag and memory word, and compares the ports on every clock. This run covers every size, every offset and both signed settings, with varying memory latency and with stray data-return strobes.

// File: rtl/load_aligner_pkg.sv
package load_aligner_pkg;
  localparam int DATA_W = 32;
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef struct packed {
    logic capture;  // latch request, compute read address/size
    logic load;     // memory data returned, register formatted result
  } ctrlStrobe_t;
endpackage

// File: rtl/load_aligner_fmt.sv
module load_aligner_fmt
  import load_aligner_pkg::*;
(
  input  logic [DATA_W-1:0] memData,
  input  logic [OFF_W-1:0]  offset,
  input  logic [1:0]        effSize,
  input  logic              sgn,
  output logic [DATA_W-1:0] fmtData
);
  logic [DATA_W-1:0] rotWord [LANES];
  logic [7:0]        byteLane [LANES];
  logic [15:0]       halfLane [LANES/2];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign byteLane[i] = memData[8*i +: 8];
    if (i == 0) begin : g_rot0
      assign rotWord[i] = memData;
    end else begin : g_rotN
      assign rotWord[i] = {memData[8*i-1:0], memData[DATA_W-1:8*i]};
    end
  end

  for (genvar j = 0; j < LANES/2; j++) begin : g_half
    assign halfLane[j] = memData[16*j +: 16];
  end

  logic [7:0]  selByte;
  logic [15:0] selHalf;

  always_comb begin
    selByte = byteLane[offset];
    selHalf = halfLane[offset[OFF_W-1:1]];
    case (effSize)
      SZ_BYTE: fmtData = sgn ? {{(DATA_W-8){selByte[7]}}, selByte}
                             : {{(DATA_W-8){1'b0}}, selByte};
      SZ_HALF: begin
        if (offset[0])
          fmtData = {selHalf[7:0], {(DATA_W-16){1'b0}}, selHalf[15:8]};
        else if (sgn)
          fmtData = {{(DATA_W-16){selHalf[15]}}, selHalf};
        else
          fmtData = {{(DATA_W-16){1'b0}}, selHalf};
      end
      default: fmtData = rotWord[offset];
    endcase
  end
endmodule

// File: rtl/load_aligner_ctrl.sv
module load_aligner_ctrl
  import load_aligner_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memRdDone,
  output logic        reqReady,
  output logic        memRdValid,
  output logic        rspValid,
  output ctrlStrobe_t strobe
);
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} state_e;
  state_e state, stateNext;

  always_comb begin
    reqReady       = (state == ST_IDLE);
    memRdValid     = (state == ST_ISSUE);
    strobe.capture = reqValid && (state == ST_IDLE);
    strobe.load    = memRdDone && (state == ST_WAIT);
    stateNext      = state;
    case (state)
      ST_IDLE:  if (reqValid) stateNext = ST_ISSUE;
      ST_ISSUE: stateNext = ST_WAIT;
      ST_WAIT:  if (memRdDone) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      rspValid <= 1'b0;
    end else begin
      state    <= stateNext;
      rspValid <= strobe.load;
    end
  end
endmodule

// File: rtl/load_aligner_dp.sv
module load_aligner_dp
  import load_aligner_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqSigned,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic [1:0]        memRdSize,
  output logic [DATA_W-1:0] rspData
);
  logic [OFF_W-1:0]  heldOff;
  logic              heldSigned;
  logic              misSignedHalf;
  logic [1:0]        reqEffSize;
  logic [ADDR_W-1:0] reqRdAddr;
  logic [DATA_W-1:0] fmtData;

  always_comb begin
    misSignedHalf = (reqSize == SZ_HALF) && reqSigned && reqAddr[0];
    if (misSignedHalf)          reqEffSize = SZ_BYTE;
    else if (reqSize == SZ_BYTE) reqEffSize = SZ_BYTE;
    else if (reqSize == SZ_HALF) reqEffSize = SZ_HALF;
    else                         reqEffSize = SZ_WORD;
    case (reqEffSize)
      SZ_BYTE: reqRdAddr = reqAddr;
      SZ_HALF: reqRdAddr = {reqAddr[ADDR_W-1:1], 1'b0};
      default: reqRdAddr = {reqAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldOff    <= '0;
      heldSigned <= 1'b0;
      memRdAddr  <= '0;
      memRdSize  <= SZ_BYTE;
      rspData    <= '0;
    end else begin
      if (strobe.capture) begin
        heldOff    <= reqAddr[OFF_W-1:0];
        heldSigned <= reqSigned;
        memRdAddr  <= reqRdAddr;
        memRdSize  <= reqEffSize;
      end
      if (strobe.load) rspData <= fmtData;
    end
  end

  load_aligner_fmt u_fmt (
    .memData (memRdData),
    .offset  (heldOff),
    .effSize (memRdSize),
    .sgn     (heldSigned),
    .fmtData (fmtData)
  );
endmodule

// File: rtl/load_aligner.sv
module load_aligner
  import load_aligner_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqSigned,
  output logic              memRdValid,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic [1:0]        memRdSize,
  input  logic              memRdDone,
  input  logic [31:0]       memRdData,
  output logic              rspValid,
  output logic [31:0]       rspData
);
  ctrlStrobe_t strobe;

  load_aligner_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .memRdDone  (memRdDone),
    .reqReady   (reqReady),
    .memRdValid (memRdValid),
    .rspValid   (rspValid),
    .strobe     (strobe)
  );

  load_aligner_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqAddr   (reqAddr),
    .reqSize   (reqSize),
    .reqSigned (reqSigned),
    .memRdData (memRdData),
    .memRdAddr (memRdAddr),
    .memRdSize (memRdSize),
    .rspData   (rspData)
  );
endmodule

// File: rtl/load_aligner_chk.sv
module load_aligner_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              memRdValid,
  input logic [ADDR_W-1:0] memRdAddr,
  input logic [1:0]        memRdSize,
  input logic              rspValid
);
  AST_ACCEPT_ISSUES: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> memRdValid);  // R2
  AST_ISSUE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    memRdValid |=> !memRdValid);  // R2
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    memRdValid |-> !reqReady);  // R3
  AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);  // R3
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);  // R4
  AST_RSP_READY: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> reqReady && !memRdValid);  // R3
  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memRdValid && memRdSize == 2'd2 |-> memRdAddr[1:0] == 2'b00);  // R6
  AST_HALF_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memRdValid && memRdSize == 2'd1 |-> !memRdAddr[0]);  // R8
endmodule

bind load_aligner load_aligner_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .memRdValid (memRdValid),
  .memRdAddr  (memRdAddr),
  .memRdSize  (memRdSize),
  .rspValid   (rspValid)
);

// File: tb/load_aligner_bench.sv
module load_aligner_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic        reqSigned = 1'b0;
  logic        memRdValid;
  logic [31:0] memRdAddr;
  logic [1:0]  memRdSize;
  logic        memRdDone = 1'b0;
  logic [31:0] memRdData = '0;
  logic        rspValid;
  logic [31:0] rspData;

  int numChecks = 0;
  int numErr = 0;

  always #5 clk = ~clk;

  load_aligner #(.ADDR_W(32)) u_load_aligner (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    numChecks++;
    if (act !== exp) begin
      numErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model, written from the requirements.
  function automatic logic [31:0] refData(input logic [31:0] a, input int sz,
                                          input bit sg, input logic [31:0] w);
    int off = a % 4;
    logic [63:0] dbl;
    logic [31:0] bt, hw;
    bt = (w >> (8 * off)) & 32'hFF;
    if (sz == 0 || (sz == 1 && sg && off % 2 == 1))
      return (sg && bt[7]) ? (bt | 32'hFFFF_FF00) : bt;
    if (sz == 1) begin
      hw = (w >> (8 * (off - off % 2))) & 32'hFFFF;
      if (off % 2 == 1) begin
        dbl = {hw, hw};
        return dbl[39:8];
      end
      return (sg && hw[15]) ? (hw | 32'hFFFF_0000) : hw;
    end
    dbl = {w, w} >> (8 * off);
    return dbl[31:0];
  endfunction

  function automatic string reqTag(input int sz, input bit sg, input int off);
    if (sz == 2) return (off == 0) ? "R5" : "R6";
    if (sz == 1 && !sg) return (off % 2 == 0) ? "R7" : "R8";
    if (sz == 1) return (off % 2 == 0) ? "R9" : "R10";
    return "R11";
  endfunction

  // Entered at a negedge; returns at the negedge where rspValid is high.
  task automatic runLoad(input logic [31:0] a, input int sz, input bit sg,
                         input logic [31:0] word, input int lat, input bit stray);
    int off = a % 4;
    int effSz;
    logic [31:0] effAddr;
    string tag = reqTag(sz, sg, off);
    effSz = (sz == 1 && sg && off % 2 == 1) ? 0 : sz;
    effAddr = (effSz == 2) ? (a & ~32'h3) : (effSz == 1) ? (a & ~32'h1) : a;
    chk("R3 ready before accept", {31'b0, reqReady}, 32'd1);
    reqValid = 1'b1; reqAddr = a; reqSize = 2'(sz); reqSigned = sg; memRdDone = 1'b0;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R2 read strobe", {31'b0, memRdValid}, 32'd1);
    chk({tag, " read addr"}, memRdAddr, effAddr);
    chk({tag, " read size"}, {30'b0, memRdSize}, effSz);
    chk("R3 busy", {31'b0, reqReady}, 32'd0);
    memRdDone = stray;                       // R12: done in strobe cycle
    memRdData = ~word;
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      memRdDone = 1'b0;
      chk("R2 single strobe", {31'b0, memRdValid}, 32'd0);
      chk(stray ? "R12 stray done" : "R4 no early rsp", {31'b0, rspValid}, 32'd0);
      chk("R3 busy wait", {31'b0, reqReady}, 32'd0);
    end
    @(negedge clk);
    memRdDone = 1'b1; memRdData = word;
    chk("R4 no rsp before done", {31'b0, rspValid}, 32'd0);
    @(negedge clk);
    memRdDone = 1'b0;
    chk("R4 rsp strobe", {31'b0, rspValid}, 32'd1);
    chk({tag, " data"}, rspData, refData(a, sz, sg, word));
    chk("R3 ready with rsp", {31'b0, reqReady}, 32'd1);
  endtask

  task automatic idle(input int n, input bit stray);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(stray ? "R12 idle done ignored" : "R4 rsp one cycle", {31'b0, rspValid}, 32'd0);
      chk("R3 idle ready", {31'b0, reqReady}, 32'd1);
      memRdDone = stray;
      memRdData = 32'hDEAD_BEEF;
    end
    @(negedge clk);
    chk("R12 no rsp after stray", {31'b0, rspValid}, 32'd0);
    memRdDone = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    numErr++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", numChecks, 0);
    $display("Result: errors=%0d of %0d checks", numErr, numChecks);
    $finish;
  end

  initial begin
    logic [31:0] words [4] = '{32'h80C1_7FA5, 32'h3F82_E114, 32'hF00D_8001, 32'h1234_5678};
    repeat (3) @(negedge clk);
    chk("R1 ready", {31'b0, reqReady}, 32'd1);
    chk("R1 strobe", {31'b0, memRdValid}, 32'd0);
    chk("R1 rsp", {31'b0, rspValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    for (int w = 0; w < 4; w++)
      for (int sz = 0; sz < 3; sz++)
        for (int off = 0; off < 4; off++)
          for (int sg = 0; sg < 2; sg++) begin
            runLoad(32'h2000_0040 + 32'(16 * w) + 32'(off), sz, sg[0], words[w],
                    (off + sz + w) % 4, (sg + off) % 3 == 1);
            // back-to-back acceptance in the response cycle on some loads
            if ((off + w) % 2 == 0) idle(1 + sz, sg[0]);
          end
    idle(2, 1'b1);
    $display("Result: errors=%0d of %0d checks", numErr, numChecks);
    $finish;
  end
endmodule